// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while the branch is still in the decode stage of a five-stage in-order pipeline. Fetch keeps going sequentially by default. When the decoded word is a branch-if-equal or a branch-if-not-equal, the unit compares the two source operands and, if the branch is taken, steers the program counter to the branch target. The comparison uses operands that may be bypassed from the two later pipeline registers. In the same cycle it clears the one instruction that was fetched behind the branch. A taken branch therefore costs a single slot.

The target is formed from the incremented PC held in the fetch/decode register plus the sign-extended offset field scaled by four. It is computed for every word, so the adder needs no decode in front of it. Operand equality is a bitwise XOR followed by an OR reduction. When a compared register is still being computed by the instruction directly ahead, the unit holds the branch in decode. That costs one cycle behind an ALU result and two behind a load. The pipeline control uses the stall output to freeze fetch and decode and to insert a bubble.

Top module: `id_branch_resolver`

## Requirements
- R1: `br_target` equals `ifid_pc4` plus the sign-extended `ifid_insn[15:0]` shifted left by two, for every instruction word, branch or not.
- R2: Opcode `ifid_insn[31:26]` = 6'b000100 is branch-if-equal. When it is not stalled, `pc_take` is 1 exactly when the two resolved operands are equal. The operands are named by rs = `ifid_insn[25:21]` and rt = `ifid_insn[20:16]`.
- R3: Opcode 6'b000101 is branch-if-not-equal. When it is not stalled, `pc_take` is 1 exactly when the two resolved operands differ.
- R4: A source register that is nonzero, equal to `exmem_rd`, and has `exmem_wr_en` set resolves to `exmem_value`. This source wins over every other source.
- R5: A source register that is nonzero and not matched by EX/MEM, but equal to `memwb_rd` with `memwb_wr_en` set, resolves to `memwb_value`. A source matched by neither resolves to its register-file read data.
- R6: A branch stalls (`id_stall`=1) while the instruction in ID/EX writes (`idex_wr_en`) a nonzero register equal to rs or rt. This is the single stall behind an ALU result and the first stall behind a load.
- R7: A branch stalls while EX/MEM holds a load (`exmem_mem_rd`=1) whose nonzero destination equals rs or rt. This is the second stall behind a load. After it, the value arrives through the MEM/WB bypass.
- R8: Register 0 never causes a stall and is never bypassed. Its operand is always the register-file read data.
- R9: `ifid_flush` is 1 exactly when `pc_take` is 1. Neither output is ever 1 while `id_stall` is 1.
- R10: For any other opcode, `id_stall`, `pc_take` and `ifid_flush` are all 0, whatever the hazard inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_insn | input | 32 | Instruction word in the fetch/decode register |
| ifid_pc4 | input | XLEN | Incremented PC in the fetch/decode register |
| rf_rdata_a | input | XLEN | Register-file read data for rs |
| rf_rdata_b | input | XLEN | Register-file read data for rt |
| idex_wr_en | input | 1 | Instruction in ID/EX writes a register |
| idex_rd | input | 5 | Destination register of the ID/EX instruction |
| exmem_wr_en | input | 1 | Instruction in EX/MEM writes a register |
| exmem_mem_rd | input | 1 | Instruction in EX/MEM is a load |
| exmem_rd | input | 5 | Destination register of the EX/MEM instruction |
| exmem_value | input | XLEN | ALU result held in EX/MEM |
| memwb_wr_en | input | 1 | Instruction in MEM/WB writes a register |
| memwb_rd | input | 5 | Destination register of the MEM/WB instruction |
| memwb_value | input | XLEN | Write-back value held in MEM/WB |
| br_target | output | XLEN | Computed branch target |
| pc_take | output | 1 | Select the branch target as the next PC |
| ifid_flush | output | 1 | Zero the instruction field of the fetch/decode register |
| id_stall | output | 1 | Hold fetch and decode and insert a bubble |

## Verification
The assertions are immediate checks on a purely combinational unit, so they take for granted that all inputs settle to known values before they are evaluated. They also assume a load in EX/MEM always has its write enable set, as any real load does. The bench drives every input in a single step between clock edges and forces `exmem_wr_en` high whenever it sets `exmem_mem_rd`. Random register numbers are drawn from 0 to 3 and operand values from a set of four, so collisions, register 0 and equal operands occur often.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int INSN_W  = 32;
  localparam int OPC_W   = 6;
  localparam int RAW     = 5;
  localparam int OPC_LSB = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BR_NE = 6'b000101;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2
  } br_kind_e;

  function automatic br_kind_e decode_kind(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_BR_EQ: decode_kind = BK_EQ;
      OPC_BR_NE: decode_kind = BK_NE;
      default:   decode_kind = BK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/brr_target.sv
module brr_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc4,
  input  logic [IMM_W-1:0] offset,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] scaled;

  always_comb begin
    scaled = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    target = pc4 + scaled;
  end

  always_comb begin
    p_target_align_r1: assert (target[1:0] == pc4[1:0])
      else $error("target alignment lost");
  end
endmodule

// File: rtl/brr_bypass.sv
module brr_bypass #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic [RAW-1:0]  src,
  input  logic [XLEN-1:0] rf_val,
  input  logic            exmem_wr_en,
  input  logic [RAW-1:0]  exmem_rd,
  input  logic [XLEN-1:0] exmem_value,
  input  logic            memwb_wr_en,
  input  logic [RAW-1:0]  memwb_rd,
  input  logic [XLEN-1:0] memwb_value,
  output logic [XLEN-1:0] opnd
);
  logic live, hit_em, hit_mw;

  always_comb begin
    live   = (src != '0);
    hit_em = live && exmem_wr_en && (exmem_rd == src);
    hit_mw = live && memwb_wr_en && (memwb_rd == src);
    if (hit_em)      opnd = exmem_value;
    else if (hit_mw) opnd = memwb_value;
    else             opnd = rf_val;
  end

  always_comb begin
    if (src == '0)
      p_zero_unbypassed_r8: assert (opnd == rf_val)
        else $error("register 0 bypassed");
    if (src != '0 && exmem_wr_en && exmem_rd == src)
      p_exmem_first_r4: assert (opnd == exmem_value)
        else $error("EX/MEM source lost priority");
  end
endmodule

// File: rtl/brr_hazard.sv
module brr_hazard #(
  parameter int RAW = 5
) (
  input  logic           is_branch,
  input  logic [RAW-1:0] src_a,
  input  logic [RAW-1:0] src_b,
  input  logic           idex_wr_en,
  input  logic [RAW-1:0] idex_rd,
  input  logic           exmem_mem_rd,
  input  logic [RAW-1:0] exmem_rd,
  output logic           stall
);
  logic near_hit, load_hit;

  function automatic logic uses(input logic [RAW-1:0] rd,
                                input logic [RAW-1:0] a,
                                input logic [RAW-1:0] b);
    return (rd != '0) && ((rd == a) || (rd == b));
  endfunction

  always_comb begin
    near_hit = idex_wr_en && uses(idex_rd, src_a, src_b);
    load_hit = exmem_mem_rd && uses(exmem_rd, src_a, src_b);
    stall    = is_branch && (near_hit || load_hit);
  end

  always_comb begin
    if (src_a == '0 && src_b == '0)
      p_r0_no_stall_r8: assert (!stall)
        else $error("stall on register 0");
  end
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     ifid_insn,
  input  logic [XLEN-1:0] ifid_pc4,
  input  logic [XLEN-1:0] rf_rdata_a,
  input  logic [XLEN-1:0] rf_rdata_b,
  input  logic            idex_wr_en,
  input  logic [4:0]      idex_rd,
  input  logic            exmem_wr_en,
  input  logic            exmem_mem_rd,
  input  logic [4:0]      exmem_rd,
  input  logic [XLEN-1:0] exmem_value,
  input  logic            memwb_wr_en,
  input  logic [4:0]      memwb_rd,
  input  logic [XLEN-1:0] memwb_value,
  output logic [XLEN-1:0] br_target,
  output logic            pc_take,
  output logic            ifid_flush,
  output logic            id_stall
);
  import brr_pkg::*;

  localparam int NSRC = 2;

  br_kind_e           kind;
  logic               is_branch;
  logic [RAW-1:0]     src   [NSRC];
  logic [XLEN-1:0]    rfv   [NSRC];
  logic [XLEN-1:0]    opnd  [NSRC];
  logic [XLEN-1:0]    diff;
  logic               differ;

  always_comb begin
    kind      = decode_kind(ifid_insn[OPC_LSB +: OPC_W]);
    is_branch = (kind != BK_NONE);
    src[0]    = ifid_insn[RS_LSB +: RAW];
    src[1]    = ifid_insn[RT_LSB +: RAW];
    rfv[0]    = rf_rdata_a;
    rfv[1]    = rf_rdata_b;
  end

  brr_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_target (
    .pc4    (ifid_pc4),
    .offset (ifid_insn[IMM_W-1:0]),
    .target (br_target)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    brr_bypass #(.XLEN(XLEN), .RAW(RAW)) u_byp (
      .src         (src[g]),
      .rf_val      (rfv[g]),
      .exmem_wr_en (exmem_wr_en),
      .exmem_rd    (exmem_rd),
      .exmem_value (exmem_value),
      .memwb_wr_en (memwb_wr_en),
      .memwb_rd    (memwb_rd),
      .memwb_value (memwb_value),
      .opnd        (opnd[g])
    );
  end

  brr_hazard #(.RAW(RAW)) u_hazard (
    .is_branch    (is_branch),
    .src_a        (src[0]),
    .src_b        (src[1]),
    .idex_wr_en   (idex_wr_en),
    .idex_rd      (idex_rd),
    .exmem_mem_rd (exmem_mem_rd),
    .exmem_rd     (exmem_rd),
    .stall        (id_stall)
  );

  always_comb begin
    diff       = opnd[0] ^ opnd[1];
    differ     = |diff;
    pc_take    = is_branch && !id_stall && ((kind == BK_NE) ? differ : !differ);
    ifid_flush = pc_take;
  end

  always_comb begin
    p_no_flush_in_stall_r9: assert (!(ifid_flush && id_stall))
      else $error("flush during stall");
    p_flush_is_take_r9: assert (ifid_flush == pc_take)
      else $error("flush and take disagree");
    if (!is_branch)
      p_quiet_non_branch_r10: assert (!id_stall && !pc_take)
        else $error("non-branch acted");
  end
endmodule

// File: tb/test_id_branch_resolver.sv
module test_id_branch_resolver;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0]     ifid_insn = '0;
  logic [XLEN-1:0] ifid_pc4 = '0, rf_rdata_a = '0, rf_rdata_b = '0;
  logic            idex_wr_en = 0, exmem_wr_en = 0, exmem_mem_rd = 0, memwb_wr_en = 0;
  logic [4:0]      idex_rd = '0, exmem_rd = '0, memwb_rd = '0;
  logic [XLEN-1:0] exmem_value = '0, memwb_value = '0;
  logic [XLEN-1:0] br_target;
  logic            pc_take, ifid_flush, id_stall;

  int checks = 0, fails = 0;
  bit done = 0;

  id_branch_resolver #(.XLEN(XLEN)) i_id_branch_resolver (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [31:0] m_target();
    logic [31:0] off;
    off = {{14{ifid_insn[15]}}, ifid_insn[15:0], 2'b00};
    return ifid_pc4 + off;
  endfunction

  function automatic logic [31:0] m_opnd(logic [4:0] r, logic [31:0] rf);
    if (r == 0) return rf;
    if (exmem_wr_en && exmem_rd == r) return exmem_value;
    if (memwb_wr_en && memwb_rd == r) return memwb_value;
    return rf;
  endfunction

  function automatic logic m_is_br();
    return ifid_insn[31:26] == 6'b000100 || ifid_insn[31:26] == 6'b000101;
  endfunction

  function automatic logic m_stall_near();
    logic [4:0] rs, rt;
    rs = ifid_insn[25:21]; rt = ifid_insn[20:16];
    return m_is_br() && idex_wr_en && idex_rd != 0 && (idex_rd == rs || idex_rd == rt);
  endfunction

  function automatic logic m_stall_load();
    logic [4:0] rs, rt;
    rs = ifid_insn[25:21]; rt = ifid_insn[20:16];
    return m_is_br() && exmem_mem_rd && exmem_rd != 0 && (exmem_rd == rs || exmem_rd == rt);
  endfunction

  function automatic logic m_take();
    logic eq;
    eq = m_opnd(ifid_insn[25:21], rf_rdata_a) == m_opnd(ifid_insn[20:16], rf_rdata_b);
    if (!m_is_br() || m_stall_near() || m_stall_load()) return 1'b0;
    return (ifid_insn[31:26] == 6'b000100) ? eq : !eq;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic clear_pipe();
    idex_wr_en = 0; idex_rd = 0; exmem_wr_en = 0; exmem_mem_rd = 0; exmem_rd = 0;
    memwb_wr_en = 0; memwb_rd = 0; exmem_value = 0; memwb_value = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic check_all();
    string st, tk;
    st = m_stall_near() ? "R6" : (m_stall_load() ? "R7" : "R10");
    tk = !m_is_br() ? "R10" : (ifid_insn[31:26] == 6'b000100 ? "R2" : "R3");
    chk("R1 target", br_target, m_target());
    chk({st, " stall"}, {31'd0, id_stall}, {31'd0, m_stall_near() || m_stall_load()});
    chk({tk, " take"}, {31'd0, pc_take}, {31'd0, m_take()});
    chk("R9 flush", {31'd0, ifid_flush}, {31'd0, m_take()});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1badc0de);
    // Idle state: all inputs zero, nothing asserted (R10)
    settle();
    chk("R10 idle stall", {31'd0, id_stall}, 0);
    chk("R10 idle take", {31'd0, pc_take}, 0);
    chk("R1 idle target", br_target, 0);

    // Negative offset target (R1)
    @(posedge clk);
    ifid_insn = mk(6'h00, 5'd0, 5'd0, 16'hFFFE); ifid_pc4 = 32'h0000_1000;
    settle();
    chk("R1 negative offset", br_target, 32'h0000_0FF8);

    // Load then beq r2,r3: two stalls, then bypass from MEM/WB (R6, R7, R5)
    @(posedge clk);
    ifid_insn = mk(6'b000100, 5'd2, 5'd3, 16'h0010); ifid_pc4 = 32'h100;
    rf_rdata_a = 32'h11; rf_rdata_b = 32'h77;
    clear_pipe(); idex_wr_en = 1; idex_rd = 5'd2;
    settle();
    chk("R6 load stall 1", {31'd0, id_stall}, 1);
    chk("R9 no flush in stall", {31'd0, ifid_flush}, 0);
    @(posedge clk);
    clear_pipe(); exmem_wr_en = 1; exmem_mem_rd = 1; exmem_rd = 5'd2; exmem_value = 32'hdead;
    settle();
    chk("R7 load stall 2", {31'd0, id_stall}, 1);
    @(posedge clk);
    clear_pipe(); memwb_wr_en = 1; memwb_rd = 5'd2; memwb_value = 32'h77;
    settle();
    chk("R7 stall over", {31'd0, id_stall}, 0);
    chk("R5 memwb bypass take", {31'd0, pc_take}, 1);
    chk("R9 flush on take", {31'd0, ifid_flush}, 1);

    // ALU then bne r3,r4: one stall, then EX/MEM bypass wins over MEM/WB (R6, R4)
    @(posedge clk);
    ifid_insn = mk(6'b000101, 5'd3, 5'd4, 16'h0004);
    rf_rdata_a = 32'h5; rf_rdata_b = 32'h9;
    clear_pipe(); idex_wr_en = 1; idex_rd = 5'd3;
    settle();
    chk("R6 alu stall", {31'd0, id_stall}, 1);
    @(posedge clk);
    clear_pipe(); exmem_wr_en = 1; exmem_rd = 5'd3; exmem_value = 32'h9;
    memwb_wr_en = 1; memwb_rd = 5'd3; memwb_value = 32'h1;
    settle();
    chk("R6 single stall", {31'd0, id_stall}, 0);
    chk("R4 exmem priority bne", {31'd0, pc_take}, 0);

    // Register 0 never stalls nor bypasses (R8)
    @(posedge clk);
    ifid_insn = mk(6'b000100, 5'd0, 5'd0, 16'h0);
    rf_rdata_a = 32'h0; rf_rdata_b = 32'h0;
    clear_pipe(); idex_wr_en = 1; exmem_wr_en = 1; exmem_mem_rd = 1; exmem_value = 32'h3;
    memwb_wr_en = 1; memwb_value = 32'h4;
    settle();
    chk("R8 r0 no stall", {31'd0, id_stall}, 0);
    chk("R8 r0 no bypass", {31'd0, pc_take}, 1);

    // Non-branch with hazards present (R10)
    @(posedge clk);
    ifid_insn = mk(6'h23, 5'd1, 5'd1, 16'h0);
    clear_pipe(); idex_wr_en = 1; idex_rd = 5'd1;
    settle();
    chk("R10 non-branch no stall", {31'd0, id_stall}, 0);
    chk("R10 non-branch no flush", {31'd0, ifid_flush}, 0);

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      @(posedge clk);
      case ($urandom % 4)
        0: op = 6'b000100;
        1: op = 6'b000101;
        2: op = 6'h00;
        default: op = 6'h23;
      endcase
      ifid_insn  = mk(op, 5'($urandom % 4), 5'($urandom % 4), 16'($urandom));
      ifid_pc4   = {$urandom, 2'b00} >> 2 << 2;
      rf_rdata_a = $urandom % 4; rf_rdata_b = $urandom % 4;
      idex_wr_en = 1'($urandom); idex_rd = 5'($urandom % 4);
      exmem_mem_rd = ($urandom % 4 == 0);
      exmem_wr_en = exmem_mem_rd | 1'($urandom);
      exmem_rd = 5'($urandom % 4); exmem_value = $urandom % 4;
      memwb_wr_en = 1'($urandom); memwb_rd = 5'($urandom % 4); memwb_value = $urandom % 4;
      settle();
      check_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule